// File: doc/BRIEF.md
# Self-Correcting Switch-Tail Timing Generator

This block is a parameterised k-stage shift-register counter whose last stage is inverted before it re-enters the first stage. With this feedback the register walks through 2k distinct codes rather than the k codes a plain circulating single-bit register gives. Each legal code is decoded into one line of a 2k-wide one-hot timing bus. Every timing line looks at exactly two adjacent stages, so the decoder stays shallow whatever the value of k.

A k-stage register can hold 2^k codes, and only 2k of them are legal. Noise or an upset can leave the register in one of the unused codes. The block detects these codes and sends the register straight to all zeros on the next enabled clock, so it returns to the legal cycle in a single step. While the register holds an unused code, the timing bus is driven to all zeros. A parallel seed load lets the register be set to any code. The bench uses this load to reach the unused codes through the ports.

Top module: `jc_timing_gen`

## Requirements
- R1: A synchronous reset sets the state to all zeros. After reset the timing bus shows only bit 0.
- R2: When enabled and holding a legal code, the register shifts one place toward bit 0 on each clock. The inverse of state bit 0 enters bit STAGES-1. For 4 stages, written MSB first, the codes run 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R3: From any legal code, 2·STAGES enabled clocks bring the register back to the same code.
- R4: For a legal code reached n enabled clocks after all zeros (0 ≤ n < 2·STAGES), timing bus bit n is 1 and every other bit is 0.
- R5: When enabled and holding an illegal code, the register loads all zeros on the next clock. An illegal code is any code with more than one change between adjacent stages.
- R6: While the register holds an illegal code, the timing bus is all zeros.
- R7: With enable low and no seed load, the state and the timing bus hold their values, including when the code is illegal.
- R8: A seed load copies the seed value into the state on the next clock, whatever the level of enable. Reset takes priority over a seed load.
- R9: From any of the 2^STAGES codes, after one enabled clock the timing bus is one-hot on every later enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable |
| seed_en_i | input | 1 | Parallel seed load strobe |
| seed_val_i | input | STAGES | Code to load |
| state_o | output | STAGES | Raw register state |
| phase_o | output | 2·STAGES | One-hot timing bus |

## Verification
The bench seeds each of the sixteen 4-stage codes. For every code it checks the decoded bus and the state one enabled clock later. It then follows a full cycle of 2k steps to confirm that the bus stays one-hot and comes back to its starting line. A design that missed an illegal pattern would stay in a short parasitic loop. That loop shows as a wrong state after the step, or as a bus with no bit or two bits set. A decoder that used the wrong neighbouring pair would light the wrong line on at least one legal code. The bench also holds an illegal code with enable low, loads a seed while enable is low, and applies reset together with a seed. A design that let enable gate the load, or gave the load priority over reset, fails one of these.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int unsigned JC_DEFAULT_STAGES = 4;

    // What the register does on the coming clock edge
    typedef enum logic [1:0] {
        JC_HOLD  = 2'd0,
        JC_SHIFT = 2'd1,
        JC_SEED  = 2'd2,
        JC_CLEAR = 2'd3
    } jc_action_e;

endpackage

// File: rtl/jc_code_check.sv
// Flags a code as legal when adjacent stages differ in at most one place.
module jc_code_check #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] code_i,
    output logic             legal_o
);
    localparam int unsigned CNT_W = $clog2(WIDTH) + 1;

    logic [WIDTH-2:0] edge_w;
    logic [CNT_W-1:0] edges_cnt;

    genvar g;
    generate
        for (g = 0; g < WIDTH - 1; g++) begin : g_edge
            assign edge_w[g] = code_i[g] ^ code_i[g+1];
        end
    endgenerate

    always_comb begin
        edges_cnt = '0;
        for (int i = 0; i < WIDTH - 1; i++) begin
            edges_cnt = edges_cnt + CNT_W'(edge_w[i]);
        end
    end

    assign legal_o = (edges_cnt <= CNT_W'(1));

endmodule

// File: rtl/jc_phase_decode.sv
// Two-input decode of each switch-tail step; gated off for illegal codes.
module jc_phase_decode #(
    parameter int unsigned WIDTH  = 4,
    localparam int unsigned PHASES = 2 * WIDTH
) (
    input  logic [WIDTH-1:0]  code_i,
    input  logic              legal_i,
    output logic [PHASES-1:0] phase_o
);
    logic [PHASES-1:0] raw_w;

    // step 0: all zeros, step WIDTH: all ones
    assign raw_w[0]     = ~code_i[WIDTH-1] & ~code_i[0];
    assign raw_w[WIDTH] =  code_i[WIDTH-1] &  code_i[0];

    genvar j;
    generate
        for (j = 1; j < WIDTH; j++) begin : g_step
            // filling with ones from the top: boundary between stage WIDTH-j and below
            assign raw_w[j]         =  code_i[WIDTH-j] & ~code_i[WIDTH-j-1];
            // draining ones from the top
            assign raw_w[WIDTH + j] = ~code_i[WIDTH-j] &  code_i[WIDTH-j-1];
        end
    endgenerate

    assign phase_o = legal_i ? raw_w : '0;

endmodule

// File: rtl/jc_timing_gen.sv
module jc_timing_gen
    import jc_pkg::*;
#(
    parameter int unsigned STAGES = JC_DEFAULT_STAGES,
    localparam int unsigned PHASES = 2 * STAGES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              seed_en_i,
    input  logic [STAGES-1:0] seed_val_i,
    output logic [STAGES-1:0] state_o,
    output logic [PHASES-1:0] phase_o
);

    typedef struct packed {
        logic [STAGES-1:0] code;
    } jc_regs_t;

    jc_regs_t   regs_d, regs_q;
    jc_action_e action;
    logic       legal_w;

    jc_code_check #(.WIDTH(STAGES)) code_check_i (
        .code_i  (regs_q.code),
        .legal_o (legal_w)
    );

    jc_phase_decode #(.WIDTH(STAGES)) phase_decode_i (
        .code_i  (regs_q.code),
        .legal_i (legal_w),
        .phase_o (phase_o)
    );

    always_comb begin
        regs_d = regs_q;
        if (seed_en_i)         action = JC_SEED;
        else if (!en_i)        action = JC_HOLD;
        else if (!legal_w)     action = JC_CLEAR;
        else                   action = JC_SHIFT;

        unique case (action)
            JC_SEED:  regs_d.code = seed_val_i;
            JC_SHIFT: regs_d.code = {~regs_q.code[0], regs_q.code[STAGES-1:1]};
            JC_CLEAR: regs_d.code = '0;
            default:  regs_d.code = regs_q.code;
        endcase
        if (rst_i) regs_d.code = '0;
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.code;

endmodule

// File: rtl/jc_timing_gen_chk.sv
module jc_timing_gen_chk #(
    parameter int unsigned STAGES = 4,
    localparam int unsigned PHASES = 2 * STAGES
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              en_i,
    input logic              seed_en_i,
    input logic [STAGES-1:0] seed_val_i,
    input logic [STAGES-1:0] state_o,
    input logic [PHASES-1:0] phase_o
);

    // R1
    a_r1_reset_zero: assert property (@(posedge clk_i)
        rst_i |=> (state_o == '0) && (phase_o == PHASES'(1)));

    // R4, R6
    a_r4_onehot_or_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(phase_o));

    // R2
    a_r2_shift: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_en_i && en_i && phase_o != '0) |=>
        state_o == {~$past(state_o[0]), $past(state_o[STAGES-1:1])});

    // R5
    a_r5_clear_illegal: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_en_i && en_i && phase_o == '0) |=> state_o == '0);

    // R7
    a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_en_i && !en_i) |=> $stable(state_o) && $stable(phase_o));

    // R8
    a_r8_seed: assert property (@(posedge clk_i) disable iff (rst_i)
        seed_en_i |=> state_o == $past(seed_val_i));

    // R9
    a_r9_recovered: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_en_i && en_i) |=> $countones(phase_o) == 1);

endmodule

bind jc_timing_gen jc_timing_gen_chk #(.STAGES(STAGES)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .seed_en_i  (seed_en_i),
    .seed_val_i (seed_val_i),
    .state_o    (state_o),
    .phase_o    (phase_o)
);

// File: tb/jc_timing_gen_tb_top.sv
`timescale 1ns/1ps
module jc_timing_gen_tb_top;

    localparam int unsigned STAGES = 4;
    localparam int unsigned PHASES = 2 * STAGES;

    // {seed[3:0], state after one enabled clock[3:0], phase while seeded[7:0]}
    localparam logic [15:0] VEC [16] = '{
        16'h0801, 16'h8C02, 16'hCE04, 16'hEF08,
        16'hF710, 16'h7320, 16'h3140, 16'h1080,
        16'h2000, 16'h4000, 16'h5000, 16'h6000,
        16'h9000, 16'hA000, 16'hB000, 16'hD000
    };

    logic              clk = 1'b0;
    logic              rst, en, seed_en;
    logic [STAGES-1:0] seed_val;
    logic [STAGES-1:0] state_o;
    logic [PHASES-1:0] phase_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    jc_timing_gen #(.STAGES(STAGES)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .en_i       (en),
        .seed_en_i  (seed_en),
        .seed_val_i (seed_val),
        .state_o    (state_o),
        .phase_o    (phase_o)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int idx;
        rst = 1'b1; en = 1'b0; seed_en = 1'b0; seed_val = '0;
        tick(); tick();
        // R1: reset state
        chk(state_o == 4'h0, "R1 state", 16'(state_o), 16'h0);
        chk(phase_o == 8'h01, "R1 phase", 16'(phase_o), 16'h01);
        rst = 1'b0;

        foreach (VEC[v]) begin
            seed_en = 1'b1; en = 1'b0; seed_val = VEC[v][15:12];
            tick();
            seed_en = 1'b0;
            // R8 load, R4/R6 decode of the seeded code
            chk(state_o == VEC[v][15:12], "R8 seed", 16'(state_o), 16'(VEC[v][15:12]));
            chk(phase_o == VEC[v][7:0], "R4/R6 decode", 16'(phase_o), 16'(VEC[v][7:0]));
            idx = 0;
            for (int b = 0; b < PHASES; b++) if (VEC[v][b]) idx = (b + 1) % PHASES;
            en = 1'b1;
            tick();
            // R2 legal step, R5 clear of illegal code
            chk(state_o == VEC[v][11:8], "R2/R5 step", 16'(state_o), 16'(VEC[v][11:8]));
            for (int c = 0; c < PHASES; c++) begin
                // R9 one-hot after recovery, R4 ordering
                chk(phase_o == PHASES'(1) << idx, "R9/R4 cycle", 16'(phase_o), 16'(PHASES'(1) << idx));
                tick();
                idx = (idx + 1) % PHASES;
            end
            // R3: full period returns to the code just after the step
            chk(state_o == VEC[v][11:8], "R3 period", 16'(state_o), 16'(VEC[v][11:8]));
            en = 1'b0;
        end

        // R7: illegal code held with enable low
        seed_en = 1'b1; seed_val = 4'h5; tick(); seed_en = 1'b0;
        tick(); tick(); tick();
        chk(state_o == 4'h5, "R7 hold illegal", 16'(state_o), 16'h5);
        chk(phase_o == 8'h00, "R7/R6 hold phase", 16'(phase_o), 16'h0);

        // R7: legal code held with enable low
        seed_en = 1'b1; seed_val = 4'hE; tick(); seed_en = 1'b0;
        tick(); tick();
        chk(state_o == 4'hE, "R7 hold legal", 16'(state_o), 16'hE);
        chk(phase_o == 8'h08, "R7 hold phase", 16'(phase_o), 16'h08);

        // R8: seed wins over enable
        en = 1'b1; seed_en = 1'b1; seed_val = 4'hB; tick(); seed_en = 1'b0; en = 1'b0;
        chk(state_o == 4'hB, "R8 seed with enable", 16'(state_o), 16'hB);

        // R8/R1: reset beats seed
        rst = 1'b1; seed_en = 1'b1; seed_val = 4'h7; tick(); rst = 1'b0; seed_en = 1'b0;
        chk(state_o == 4'h0, "R8 reset priority", 16'(state_o), 16'h0);
        chk(phase_o == 8'h01, "R1 phase after reset", 16'(phase_o), 16'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule